// File: doc/BRIEF.md
# LCD Controller Register Bank

This block is the software-visible register bank of a colour LCD controller. A simple 32-bit word bus reaches it, carrying a word address, a write strobe, write data and combinational read data. It holds four panel timing words, the upper and lower frame base addresses, a control word and an interrupt mask. It also keeps a small raw interrupt status. From the first two timing words it decodes the active line width in pixels and the frame height in lines. These go to the pixel fetch and panel timing logic elsewhere.

While the controller is both enabled and powered, an internal frame tick fires once every `TICK_CYCLES` clocks. Each tick sets two status bits, the next-base flag and the vertical-compare flag. The interrupt line reflects the status bits that the mask allows through. The palette window is not stored here. Its accesses are routed out as a select, a write strobe and an index, and the palette storage returns read data through an input. One parameter swaps the word offsets of the mask and control registers. A second parameter selects which of two identification byte sets appears at the top of the window.

Top module: `lcdc_regbank`

## Requirements
- R1: After reset every register reads zero, `irq` and `lcd_on` are low, `active_width` is 16 and `active_height` is 1.
- R2: Word offsets 0–3 hold the timing words, offset 4 holds the upper base and offset 5 holds the lower base. All six read back what was written. Offsets 11 and 12 read the upper and lower base respectively.
- R3: With `ALT_OFFSETS`=0, offset 6 is the mask and offset 7 is the control word. With `ALT_OFFSETS`=1 the two are exchanged, for both reads and writes.
- R4: `lcd_on` is high only when control bit 0 (enable) and control bit 11 (power) are both 1.
- R5: `active_width` equals ((timing0 AND 0xFC) + 4) × 4.
- R6: `active_height` equals (timing1 AND 0x3FF) + 1.
- R7: A write to the control register restarts the tick counter. While `lcd_on` is high, raw status bits 2 and 3 are set on the TICK_CYCLES-th clock edge after that write and then on every TICK_CYCLES-th edge. While `lcd_on` is low, no tick occurs.
- R8: Offset 8 reads the raw status. Offset 9 reads raw status AND mask.
- R9: A write to offset 10 clears each raw status bit that is 1 in the written data. Offset 10 reads zero.
- R10: `irq` is high exactly when (raw status AND mask) is nonzero. It follows the register state one cycle after a mask write, a clear or a tick.
- R11: Word offsets 0x3F8–0x3FF return one identification byte each in bits 7:0. With `EXT_ID`=0 the bytes are 10 11 04 00 0D F0 05 B1, and with `EXT_ID`=1 they are 11 11 24 00 0D F0 05 B1.
- R12: Word offsets 0x80–0xFF assert `pal_sel`, put the address bits 6:0 on `pal_index`, return `pal_rdata`, and strobe `pal_we` on a write. All other offsets read zero, and writes to them change nothing.
- R13: When a tick and a clear write land on the same clock edge, the tick wins: bits 2 and 3 end up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | AW | Word address within the 4 KiB window |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Level interrupt, raw status AND mask nonzero |
| lcd_on | output | 1 | Controller enabled and powered |
| active_width | output | 11 | Decoded pixels per line |
| active_height | output | 11 | Decoded lines per frame |
| upper_base | output | 32 | Upper frame base address |
| lower_base | output | 32 | Lower frame base address |
| pal_sel | output | 1 | Address lies in the palette window |
| pal_we | output | 1 | Palette write strobe |
| pal_index | output | 7 | Palette word index |
| pal_rdata | input | 32 | Palette read data from external storage |

## Verification
The hardest case to reach from the ports is a clear write that lands on the same clock edge as a frame tick. The tick phase is hidden, and it depends on when the control register was last written. The bench keeps its own behavioural count of clocks since the last control write. It waits until that count reaches the last cycle before the tick, then issues the clear so that it meets the tick on the same edge. It also reaches the two variants together by driving identical bus traffic into a base-offset instance and a swapped-offset instance. Writing the same value to offsets 6 and 7 enables and unmasks both instances, but each one starts its tick on a different cycle.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_TIM,
    SEL_UPB,
    SEL_LPB,
    SEL_MASK,
    SEL_CTRL,
    SEL_RAW,
    SEL_MIS,
    SEL_ICLR,
    SEL_UPCUR,
    SEL_LPCUR,
    SEL_ID,
    SEL_PAL
  } reg_sel_e;

  localparam int CTRL_EN_BIT  = 0;
  localparam int CTRL_PWR_BIT = 11;
  localparam int ST_NEXTBASE  = 2;
  localparam int ST_VCOMP     = 3;

  function automatic logic [7:0] id_byte(input logic ext, input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = ext ? 8'h11 : 8'h10;
      3'd1:    b = 8'h11;
      3'd2:    b = ext ? 8'h24 : 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/lcdc_addr_dec.sv
module lcdc_addr_dec
  import lcdc_pkg::*;
#(
  parameter int AW          = 10,
  parameter bit ALT_OFFSETS = 1'b0
) (
  input  logic [AW-1:0] word_addr,
  output reg_sel_e      sel
);

  localparam logic [31:0] MASK_OFF = ALT_OFFSETS ? 32'd7 : 32'd6;
  localparam logic [31:0] CTRL_OFF = ALT_OFFSETS ? 32'd6 : 32'd7;
  localparam logic [31:0] PAL_LO   = 32'h80;
  localparam logic [31:0] PAL_HI   = 32'hFF;
  localparam logic [31:0] ID_LO    = (32'd1 << AW) - 32'd8;

  logic [31:0] wa;

  always_comb begin
    wa  = 32'(word_addr);
    sel = SEL_NONE;
    if (wa >= ID_LO) begin
      sel = SEL_ID;
    end else if (wa >= PAL_LO && wa <= PAL_HI) begin
      sel = SEL_PAL;
    end else if (wa <= 32'd3) begin
      sel = SEL_TIM;
    end else if (wa == MASK_OFF) begin
      sel = SEL_MASK;
    end else if (wa == CTRL_OFF) begin
      sel = SEL_CTRL;
    end else begin
      case (wa)
        32'd4:   sel = SEL_UPB;
        32'd5:   sel = SEL_LPB;
        32'd8:   sel = SEL_RAW;
        32'd9:   sel = SEL_MIS;
        32'd10:  sel = SEL_ICLR;
        32'd11:  sel = SEL_UPCUR;
        32'd12:  sel = SEL_LPCUR;
        default: sel = SEL_NONE;
      endcase
    end
  end

endmodule

// File: rtl/lcdc_frame_tick.sv
module lcdc_frame_tick #(
  parameter int TICK_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);

  localparam int CW = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(TICK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    tick   = run && !restart && (cnt_q == LAST);
    cnt_en = 1'b1;
    if (restart || !run || tick) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
    if (!run && !restart && cnt_q == '0) begin
      cnt_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lcdc_int_ctrl.sv
module lcdc_int_ctrl
  import lcdc_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          clr_we,
  input  logic [DW-1:0] clr_val,
  input  logic          mask_we,
  input  logic [DW-1:0] mask_wd,
  output logic [DW-1:0] mask_q,
  output logic [DW-1:0] raw_word,
  output logic          irq
);

  logic [DW-1:0] mask_d;
  logic [1:0]    raw_q, raw_d;
  logic          raw_en;

  always_comb begin
    mask_d = mask_wd;
    raw_d  = raw_q;
    if (clr_we) begin
      raw_d = raw_d & ~clr_val[ST_VCOMP:ST_NEXTBASE];
    end
    if (tick) begin
      raw_d = 2'b11;
    end
    raw_en = clr_we || tick;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (mask_we) begin
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  always_comb begin
    raw_word                        = '0;
    raw_word[ST_VCOMP:ST_NEXTBASE]  = raw_q;
    irq = |(raw_q & mask_q[ST_VCOMP:ST_NEXTBASE]);
  end

endmodule

// File: rtl/lcdc_regbank.sv
module lcdc_regbank
  import lcdc_pkg::*;
#(
  parameter int AW          = 10,
  parameter bit ALT_OFFSETS = 1'b0,
  parameter bit EXT_ID      = 1'b0,
  parameter int TICK_CYCLES = 1000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  output logic          irq,
  output logic          lcd_on,
  output logic [10:0]   active_width,
  output logic [10:0]   active_height,
  output logic [31:0]   upper_base,
  output logic [31:0]   lower_base,
  output logic          pal_sel,
  output logic          pal_we,
  output logic [6:0]    pal_index,
  input  logic [31:0]   pal_rdata
);

  localparam int NTIM = 4;
  localparam int DW   = 32;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  // decode
  reg_sel_e sel;

  lcdc_addr_dec #(.AW(AW), .ALT_OFFSETS(ALT_OFFSETS)) u_dec (
    .word_addr (bus_addr),
    .sel       (sel)
  );

  logic wr_tim, wr_upb, wr_lpb, wr_ctrl, wr_mask, wr_clr;
  logic [1:0] tim_idx;

  always_comb begin
    tim_idx = bus_addr[1:0];
    wr_tim  = bus_we && (sel == SEL_TIM);
    wr_upb  = bus_we && (sel == SEL_UPB);
    wr_lpb  = bus_we && (sel == SEL_LPB);
    wr_ctrl = bus_we && (sel == SEL_CTRL);
    wr_mask = bus_we && (sel == SEL_MASK);
    wr_clr  = bus_we && (sel == SEL_ICLR);
  end

  // timing words
  logic [DW-1:0] tim_q [NTIM];

  for (genvar g = 0; g < NTIM; g++) begin : g_tim
    logic tim_en;
    assign tim_en = wr_tim && (tim_idx == 2'(g));
    always_ff @(posedge clk or negedge rst_sync_n) begin
      if (!rst_sync_n) begin
        tim_q[g] <= '0;
      end else if (tim_en) begin
        tim_q[g] <= bus_wdata;
      end
    end
  end

  // base addresses and control
  logic [DW-1:0] upb_q, lpb_q, ctrl_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      upb_q <= '0;
    end else if (wr_upb) begin
      upb_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      lpb_q <= '0;
    end else if (wr_lpb) begin
      lpb_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_q <= '0;
    end else if (wr_ctrl) begin
      ctrl_q <= bus_wdata;
    end
  end

  assign lcd_on     = ctrl_q[CTRL_EN_BIT] && ctrl_q[CTRL_PWR_BIT];
  assign upper_base = upb_q;
  assign lower_base = lpb_q;

  // size decode
  logic [10:0] w_sum;

  always_comb begin
    w_sum         = {3'b000, tim_q[0][7:2], 2'b00} + 11'd4;
    active_width  = {w_sum[8:0], 2'b00};
    active_height = {1'b0, tim_q[1][9:0]} + 11'd1;
  end

  // frame tick
  logic tick;

  lcdc_frame_tick #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .run     (lcd_on),
    .restart (wr_ctrl),
    .tick    (tick)
  );

  // status, mask, interrupt
  logic [DW-1:0] mask_q, raw_word;

  lcdc_int_ctrl #(.DW(DW)) u_int (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tick     (tick),
    .clr_we   (wr_clr),
    .clr_val  (bus_wdata),
    .mask_we  (wr_mask),
    .mask_wd  (bus_wdata),
    .mask_q   (mask_q),
    .raw_word (raw_word),
    .irq      (irq)
  );

  // palette routing
  assign pal_sel   = (sel == SEL_PAL);
  assign pal_we    = bus_we && pal_sel;
  assign pal_index = bus_addr[6:0];

  // read mux
  always_comb begin
    case (sel)
      SEL_TIM:   bus_rdata = tim_q[tim_idx];
      SEL_UPB,
      SEL_UPCUR: bus_rdata = upb_q;
      SEL_LPB,
      SEL_LPCUR: bus_rdata = lpb_q;
      SEL_MASK:  bus_rdata = mask_q;
      SEL_CTRL:  bus_rdata = ctrl_q;
      SEL_RAW:   bus_rdata = raw_word;
      SEL_MIS:   bus_rdata = raw_word & mask_q;
      SEL_ID:    bus_rdata = {24'h0, id_byte(EXT_ID, bus_addr[2:0])};
      SEL_PAL:   bus_rdata = pal_rdata;
      default:   bus_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lcdc_regbank_chk.sv
module lcdc_regbank_chk #(
  parameter int AW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] bus_addr,
  input logic          bus_we,
  input logic [31:0]   bus_wdata,
  input logic          irq,
  input logic          lcd_on,
  input logic          tick,
  input logic [31:0]   mask_q,
  input logic [10:0]   active_width,
  input logic [10:0]   active_height
);

  AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == AW'(10) && bus_wdata[3:2] == 2'b11 && !tick) |=> !irq); // R9

  AST_TICK_NEEDS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> lcd_on); // R7

  AST_TICK_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mask_q[2] && !bus_we) |=> irq); // R10

  AST_IRQ_RISE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(tick) || $past(bus_we))); // R10

  AST_WIDTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(0)) |=> $stable(active_width)); // R5

  AST_HEIGHT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == AW'(1)) |=> $stable(active_height)); // R6

endmodule

bind lcdc_regbank lcdc_regbank_chk #(.AW(AW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .bus_addr      (bus_addr),
  .bus_we        (bus_we),
  .bus_wdata     (bus_wdata),
  .irq           (irq),
  .lcd_on        (lcd_on),
  .tick          (tick),
  .mask_q        (mask_q),
  .active_width  (active_width),
  .active_height (active_height)
);

// File: tb/lcdc_regbank_tb_top.sv
module lcdc_regbank_tb_top;

  localparam int AW = 10;
  localparam int T  = 16;

  logic          clk;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          we;
  logic [31:0]   wd;

  logic [31:0] rd0, rd1, prd0, prd1;
  logic        irq0, irq1, on0, on1, ps0, ps1, pw0, pw1;
  logic [10:0] wid0, wid1, hgt0, hgt1;
  logic [31:0] ub0, ub1, lb0, lb1;
  logic [6:0]  pi0, pi1;

  int checks = 0;
  int fails  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign prd0 = 32'hA500_0000 | 32'(pi0);
  assign prd1 = 32'hA500_0000 | 32'(pi1);

  lcdc_regbank #(.AW(AW), .ALT_OFFSETS(1'b0), .EXT_ID(1'b0), .TICK_CYCLES(T)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd0), .irq(irq0), .lcd_on(on0), .active_width(wid0),
    .active_height(hgt0), .upper_base(ub0), .lower_base(lb0),
    .pal_sel(ps0), .pal_we(pw0), .pal_index(pi0), .pal_rdata(prd0));

  lcdc_regbank #(.AW(AW), .ALT_OFFSETS(1'b1), .EXT_ID(1'b1), .TICK_CYCLES(T)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
    .bus_rdata(rd1), .irq(irq1), .lcd_on(on1), .active_width(wid1),
    .active_height(hgt1), .upper_base(ub1), .lower_base(lb1),
    .pal_sel(ps1), .pal_we(pw1), .pal_index(pi1), .pal_rdata(prd1));

  // behavioural reference, index 0 = base variant, 1 = swapped variant
  logic [31:0] m_tim [2][4];
  logic [31:0] m_up [2], m_lp [2], m_ctrl [2], m_mask [2], m_raw [2];
  int          m_cnt [2];
  int          rst_hold;

  function automatic logic [7:0] idb(int v, int i);
    logic [7:0] base_tab [8] = '{8'h10, 8'h11, 8'h04, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    logic [7:0] ext_tab  [8] = '{8'h11, 8'h11, 8'h24, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};
    return (v == 1) ? ext_tab[i] : base_tab[i];
  endfunction

  function automatic int ctrl_off(int v);
    return (v == 1) ? 6 : 7;
  endfunction

  function automatic int mask_off(int v);
    return (v == 1) ? 7 : 6;
  endfunction

  function automatic logic [31:0] mread(int v, int a);
    if (a >= 'h3F8) return {24'h0, idb(v, a - 'h3F8)};
    if (a >= 'h80 && a <= 'hFF) return 32'hA500_0000 | 32'(a & 'h7F);
    if (a <= 3) return m_tim[v][a];
    if (a == mask_off(v)) return m_mask[v];
    if (a == ctrl_off(v)) return m_ctrl[v];
    case (a)
      4, 11:   return m_up[v];
      5, 12:   return m_lp[v];
      8:       return m_raw[v];
      9:       return m_raw[v] & m_mask[v];
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tagof(int a);
    if (a >= 'h3F8) return "R11";
    if (a >= 'h80 && a <= 'hFF) return "R12";
    if (a <= 5 || a == 11 || a == 12) return "R2";
    if (a == 6 || a == 7) return "R3";
    if (a == 8 || a == 9) return "R8";
    if (a == 10) return "R9";
    return "R12";
  endfunction

  function automatic logic m_on(int v);
    return m_ctrl[v][0] && m_ctrl[v][11];
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
    end
  endtask

  // reference update: the DUT releases its reset two clocks after rst_n
  always @(posedge clk) begin
    if (!rst_n) rst_hold = 2;
    else if (rst_hold > 0) rst_hold--;
    for (int v = 0; v < 2; v++) begin
      if (!rst_n || rst_hold > 0) begin
        for (int k = 0; k < 4; k++) m_tim[v][k] = 32'h0;
        m_up[v] = 0; m_lp[v] = 0; m_ctrl[v] = 0; m_mask[v] = 0; m_raw[v] = 0;
        m_cnt[v] = 0;
      end else begin
        int a;
        logic tk, cw;
        a  = int'(addr);
        cw = we && (a == ctrl_off(v));
        tk = 1'b0;
        if (m_on(v) && !cw) begin
          if (m_cnt[v] == T - 1) begin
            m_cnt[v] = 0;
            tk = 1'b1;
          end else begin
            m_cnt[v]++;
          end
        end else begin
          m_cnt[v] = 0;
        end
        if (we) begin
          if (a <= 3) m_tim[v][a] = wd;
          else if (a == 4) m_up[v] = wd;
          else if (a == 5) m_lp[v] = wd;
          else if (a == ctrl_off(v)) m_ctrl[v] = wd;
          else if (a == mask_off(v)) m_mask[v] = wd;
          else if (a == 10) m_raw[v] = m_raw[v] & ~wd & 32'hC;
        end
        if (tk) m_raw[v] = m_raw[v] | 32'hC;
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (rst_n && rst_hold == 0) begin
      int a;
      a = int'(addr);
      chk(tagof(a), rd0, mread(0, a));
      chk(tagof(a), rd1, mread(1, a));
      chk("R10", 32'(irq0), 32'(|(m_raw[0] & m_mask[0] & 32'hC)));
      chk("R10", 32'(irq1), 32'(|(m_raw[1] & m_mask[1] & 32'hC)));
      chk("R4", 32'(on0), 32'(m_on(0)));
      chk("R4", 32'(on1), 32'(m_on(1)));
      chk("R5", 32'(wid0), ((m_tim[0][0] & 32'hFC) + 32'd4) * 32'd4);
      chk("R6", 32'(hgt0), (m_tim[0][1] & 32'h3FF) + 32'd1);
      chk("R12", 32'(pw0), 32'(we && a >= 'h80 && a <= 'hFF));
      chk("R2", ub1, m_up[1]);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(posedge clk); #1;
    addr = AW'(a); we = 1'b1; wd = d;
    @(posedge clk); #1;
    we = 1'b0;
  endtask

  task automatic rd(input int a);
    @(posedge clk); #1;
    addr = AW'(a);
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wd = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", 32'(irq0), 0);
    chk("R1", 32'(on0), 0);
    chk("R1", 32'(wid0), 16);
    chk("R1", 32'(hgt0), 1);
    chk("R1", rd0, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    repeat (4) @(posedge clk);
    for (int a = 0; a <= 13; a++) begin
      rd(a);
      chk("R1", rd1, 0);
    end

    // R5 R6 size decode
    wr(0, 32'h0000_00FC); rd(0); chk("R5", 32'(wid0), 1024);
    wr(0, 32'hFFFF_FF03); rd(0); chk("R5", 32'(wid0), 16);
    wr(0, 32'h0000_001F); rd(0); chk("R5", 32'(wid0), 128);
    wr(1, 32'h0000_03FF); rd(1); chk("R6", 32'(hgt0), 1024);
    wr(1, 32'hFFFF_FC05); rd(1); chk("R6", 32'(hgt0), 6);
    wr(2, 32'h1234_5678); wr(3, 32'h9ABC_DEF0);
    rd(2); chk("R2", rd0, 32'h1234_5678);
    rd(3); chk("R2", rd1, 32'h9ABC_DEF0);

    // R2 bases and current-address aliases
    wr(4, 32'h8000_1000); wr(5, 32'h8004_0000);
    rd(11); chk("R2", rd0, 32'h8000_1000);
    rd(12); chk("R2", rd0, 32'h8004_0000);
    chk("R2", ub0, 32'h8000_1000);
    chk("R2", lb0, 32'h8004_0000);

    // R4 enable needs both bits; R3 swapped offsets
    wr(7, 32'h0000_0001); rd(7); chk("R4", 32'(on0), 0);
    wr(7, 32'h0000_0800); rd(7); chk("R4", 32'(on0), 0);
    wr(7, 32'h0000_0801); rd(7); chk("R4", 32'(on0), 1);
    chk("R3", rd1, 32'h0000_0801);
    chk("R3", 32'(on1), 0);
    wr(6, 32'h0000_080D); rd(6);
    chk("R3", rd0, 32'h0000_080D);
    chk("R3", 32'(on1), 1);

    // R7 period: base was enabled by the write to offset 7
    wr(10, 32'hFFFF_FFFF);
    wr(7, 32'h0000_0801);
    addr = AW'(8);
    repeat (T - 1) @(posedge clk);
    @(negedge clk); chk("R7", rd0, 0);
    @(negedge clk); chk("R7", rd0, 32'hC);
    chk("R10", 32'(irq0), 1);
    rd(9); chk("R8", rd0, 32'hC);

    // R9 partial clears
    wr(10, 32'h0000_0004); rd(8); chk("R9", rd0, 32'h8);
    chk("R10", 32'(irq0), 1);
    wr(10, 32'h0000_0008); rd(8); chk("R9", rd0, 0);
    chk("R10", 32'(irq0), 0);
    rd(10); chk("R9", rd0, 0);

    // R13 clear aligned with the tick edge
    do begin
      @(posedge clk); #1;
    end while (m_cnt[0] != T - 1);
    addr = AW'(10); we = 1'b1; wd = 32'hFFFF_FFFF;
    @(posedge clk); #1; we = 1'b0; addr = AW'(8);
    @(negedge clk); chk("R13", rd0, 32'hC);

    // R7 ticks stop when disabled
    wr(7, 32'h0000_0800);
    wr(10, 32'hFFFF_FFFF);
    addr = AW'(8);
    repeat (3 * T) @(posedge clk);
    @(negedge clk); chk("R7", rd0, 0);
    chk("R10", 32'(irq0), 0);

    // R11 identification bytes
    for (int i = 0; i < 8; i++) begin
      rd('h3F8 + i);
      chk("R11", rd0, 32'(idb(0, i)));
      chk("R11", rd1, 32'(idb(1, i)));
    end

    // R12 palette routing and unknown offsets
    rd('h85);
    chk("R12", 32'(ps0), 1);
    chk("R12", 32'(pi0), 32'h05);
    chk("R12", rd0, 32'hA500_0005);
    wr('hC3, 32'h1111_1111);
    wr(13, 32'hFFFF_FFFF); wr('h40, 32'hFFFF_FFFF);
    wr('h100, 32'hFFFF_FFFF); wr('h3F7, 32'hFFFF_FFFF);
    rd(13);    chk("R12", rd0, 0);
    rd('h100); chk("R12", rd0, 0);
    rd('h3F7); chk("R12", rd1, 0);
    for (int a = 0; a <= 12; a++) rd(a);
    chk("R12", 32'(wid0), 128);

    repeat (4) @(posedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule